// File: doc/BRIEF.md
# Indirect Two-Bank Channel Configuration Register File

This block holds the per-channel setup of a dual-channel disk interface controller and makes it reachable from the host through only two locations. One location is a byte-wide pointer. The other is a word-wide data window. The pointer chooses one of two channel banks and one of seven register slots in that bank. Every access to the data window then reads or writes the chosen slot. If the pointer's step bit is set, the slot field advances after each data-window access, so a whole bank can be swept with back-to-back accesses.

Each bank stores the following, and drives all of it as outputs to the timing and control logic:

- the command-block and control-block base addresses;
- a general control byte;
- a 10-bit read-ahead count, split over two write-only slots, with its enable and mode-4 timing bits;
- two timing bytes.

The pointer also carries three bus option bits, which the block stores and exports. A write to the read-ahead control slot with the FIFO-clear bit set produces a single-cycle pulse for that channel.

The host port is synchronous. A request with `host_addr_i` = 0 goes to the data window, and `host_addr_i` = 1 goes to the pointer. Read data comes back one cycle after the request and is marked by `rvalid_o`.

Top module: `ide_cfg_regs`

## Requirements
- R1: The pointer byte resets to 0x50. Its fields are slot index in bits 2:0, bank in bit 3, medium select timing in bit 4 (`sel_medium_o`), burst disable in bit 5 (`burst_dis_o`), posted-write wait state in bit 6 (`post_wait_o`) and auto-step in bit 7. The three option outputs always follow the stored bits.
- R2: While pointer bit 7 is 1, every data-window access (read or write) advances the slot index by one after the access. While it is 0, the index holds.
- R3: A request with `host_we_i` = 0 returns its data on `rdata_o` with `rvalid_o` high in the next cycle, and only then. A pointer read returns the pointer in bits 7:0 with zeros above. A pointer write keeps only `host_wdata_i[7:0]`.
- R4: After reset the slots read as follows:
  - slot 0 reads 0x01F0 in bank 0 and 0x0170 in bank 1;
  - slot 4 reads 0x03F6 in bank 0 and 0x0376 in bank 1;
  - slot 1 reads 0x0001;
  - slot 5 reads 0x00F5;
  - slot 6 reads 0x00DE.
- R5: Slots 2 and 3 are write-only and always read as zero.
- R6: Auto-step goes from slot 6 (or 7) back to slot 0 and never changes the bank bit.
- R7: Slots 0 and 4 store all 16 data bits. Slots 1, 2, 3, 5 and 6 keep only bits 7:0.
- R8: The read-ahead fields come from slots 2 and 3:
  - `ra_count_o` = {slot 3 bits 1:0, slot 2 bits 7:0};
  - `ra_en_o` = slot 3 bit 7;
  - `mode4_o` = slot 3 bit 4;
  - a write to slot 3 with bit 6 set raises `fifo_clr_o` for that bank for exactly the following cycle.
- R9: `gen_cfg_o` exports slot 1. Its bits are DMA enable (bit 7), drive reset (bit 6), IORDY enable (bit 5) and I/O port enable (bit 0).
- R10: A data-window write while the slot index is 7 changes no register. A read of slot 7 returns zero.
- R11: A write reaches only the bank that pointer bit 3 selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Access request |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 1 | 0 = data window, 1 = pointer |
| host_wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| post_wait_o | output | 1 | Posted-write wait state option |
| burst_dis_o | output | 1 | Master burst disable option |
| sel_medium_o | output | 1 | Medium select-timing option |
| cmd_base_o | output | 2x16 | Command block base per bank |
| ctl_base_o | output | 2x16 | Control block base per bank |
| gen_cfg_o | output | 2x8 | General control byte per bank |
| ra_count_o | output | 2x10 | Read-ahead count per bank |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| mode4_o | output | 2 | Mode-4 timing enable per bank |
| fifo_clr_o | output | 2 | FIFO clear pulse per bank |
| data_tim_o | output | 2x8 | Data port timing per bank |
| ctl_tim_o | output | 2x8 | Command/control port timing per bank |

## Verification
The bench sweeps both banks with auto-step reads, crossing the 6-to-0 wrap, and then reads the pointer back. A design that carried the increment into the bank bit would show bank 1 there, and one that stepped only on writes would show an unmoved index. Write-only slots are read after nonzero writes, so a design that returned stored contents would fail. High data bytes are written into byte slots and a pointer write, so a design that kept them would read back a wider value. The FIFO-clear pulse is checked in both the cycle it appears and the cycle after, and on the other bank, which catches a level that sticks or a pulse sent to the wrong channel. Slot 7 writes and cross-bank writes are checked by reading the neighbouring outputs, which catches aliasing onto slot 0 or onto both banks.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;
  localparam int RA_W   = 10;
  localparam int N_BANK = 2;

  localparam logic [IDX_W-1:0] SLOT_CMD  = 3'd0;
  localparam logic [IDX_W-1:0] SLOT_GEN  = 3'd1;
  localparam logic [IDX_W-1:0] SLOT_RALO = 3'd2;
  localparam logic [IDX_W-1:0] SLOT_RAHI = 3'd3;
  localparam logic [IDX_W-1:0] SLOT_CTL  = 3'd4;
  localparam logic [IDX_W-1:0] SLOT_DTIM = 3'd5;
  localparam logic [IDX_W-1:0] SLOT_CTIM = 3'd6;

  localparam int PTR_BANK_BIT  = 3;
  localparam int PTR_MED_BIT   = 4;
  localparam int PTR_BURST_BIT = 5;
  localparam int PTR_WAIT_BIT  = 6;
  localparam int PTR_STEP_BIT  = 7;
endpackage

// File: rtl/ide_cfg_ptr.sv
module ide_cfg_ptr #(
  parameter int               PW       = 8,
  parameter int               IW       = 3,
  parameter logic [IW-1:0]    LAST_IDX = 3'd6,
  parameter logic [PW-1:0]    RST_VAL  = 8'h50,
  parameter int               STEP_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [PW-1:0] wdata_i,
  input  logic          access_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] ptr_q;
  logic [IW-1:0] idx_nxt;

  // wrap past the last slot; bank and option bits untouched
  always_comb begin
    if (ptr_q[IW-1:0] >= LAST_IDX) idx_nxt = '0;
    else                           idx_nxt = ptr_q[IW-1:0] + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= RST_VAL;
    else if (wr_i) ptr_q <= wdata_i;
    else if (access_i && ptr_q[STEP_BIT]) ptr_q[IW-1:0] <= idx_nxt;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ide_cfg_bank.sv
module ide_cfg_bank
  import ide_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CMD_RST  = 16'h01F0,
  parameter logic [DATA_W-1:0] CTL_RST  = 16'h03F6,
  parameter logic [BYTE_W-1:0] GEN_RST  = 8'h01,
  parameter logic [BYTE_W-1:0] DTIM_RST = 8'hF5,
  parameter logic [BYTE_W-1:0] CTIM_RST = 8'hDE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cmd_base_o,
  output logic [DATA_W-1:0] ctl_base_o,
  output logic [BYTE_W-1:0] gen_o,
  output logic [RA_W-1:0]   ra_count_o,
  output logic              ra_en_o,
  output logic              mode4_o,
  output logic              fifo_clr_o,
  output logic [BYTE_W-1:0] dtim_o,
  output logic [BYTE_W-1:0] ctim_o
);
  localparam int RA_HI_W = RA_W - BYTE_W;

  logic [DATA_W-1:0]  cmd_q, ctl_q;
  logic [BYTE_W-1:0]  gen_q, ralo_q, dtim_q, ctim_q;
  logic [RA_HI_W-1:0] rahi_q;
  logic               ra_en_q, mode4_q, fifo_q;
  logic [BYTE_W-1:0]  wbyte;

  assign wbyte = wdata_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_RST;
      ctl_q   <= CTL_RST;
      gen_q   <= GEN_RST;
      ralo_q  <= '0;
      rahi_q  <= '0;
      ra_en_q <= 1'b0;
      mode4_q <= 1'b0;
      dtim_q  <= DTIM_RST;
      ctim_q  <= CTIM_RST;
      fifo_q  <= 1'b0;
    end else begin
      fifo_q <= 1'b0;
      if (we_i) begin
        unique case (idx_i)
          SLOT_CMD:  cmd_q  <= wdata_i;
          SLOT_GEN:  gen_q  <= wbyte;
          SLOT_RALO: ralo_q <= wbyte;
          SLOT_RAHI: begin
            rahi_q  <= wbyte[RA_HI_W-1:0];
            ra_en_q <= wbyte[7];
            mode4_q <= wbyte[4];
            fifo_q  <= wbyte[6];
          end
          SLOT_CTL:  ctl_q  <= wdata_i;
          SLOT_DTIM: dtim_q <= wbyte;
          SLOT_CTIM: ctim_q <= wbyte;
          default: ;
        endcase
      end
    end
  end

  // write-only and unused slots read as zero
  always_comb begin
    unique case (idx_i)
      SLOT_CMD:  rdata_o = cmd_q;
      SLOT_GEN:  rdata_o = {{(DATA_W-BYTE_W){1'b0}}, gen_q};
      SLOT_CTL:  rdata_o = ctl_q;
      SLOT_DTIM: rdata_o = {{(DATA_W-BYTE_W){1'b0}}, dtim_q};
      SLOT_CTIM: rdata_o = {{(DATA_W-BYTE_W){1'b0}}, ctim_q};
      default:   rdata_o = '0;
    endcase
  end

  assign cmd_base_o = cmd_q;
  assign ctl_base_o = ctl_q;
  assign gen_o      = gen_q;
  assign ra_count_o = {rahi_q, ralo_q};
  assign ra_en_o    = ra_en_q;
  assign mode4_o    = mode4_q;
  assign fifo_clr_o = fifo_q;
  assign dtim_o     = dtim_q;
  assign ctim_o     = ctim_q;
endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_cfg_pkg::*;
#(
  parameter logic [N_BANK-1:0][DATA_W-1:0] CMD_RST = {16'h0170, 16'h01F0},
  parameter logic [N_BANK-1:0][DATA_W-1:0] CTL_RST = {16'h0376, 16'h03F6},
  parameter logic [BYTE_W-1:0]             PTR_RST = 8'h50
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           host_req_i,
  input  logic                           host_we_i,
  input  logic                           host_addr_i,
  input  logic [DATA_W-1:0]              host_wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           rvalid_o,
  output logic                           post_wait_o,
  output logic                           burst_dis_o,
  output logic                           sel_medium_o,
  output logic [N_BANK-1:0][DATA_W-1:0]  cmd_base_o,
  output logic [N_BANK-1:0][DATA_W-1:0]  ctl_base_o,
  output logic [N_BANK-1:0][BYTE_W-1:0]  gen_cfg_o,
  output logic [N_BANK-1:0][RA_W-1:0]    ra_count_o,
  output logic [N_BANK-1:0]              ra_en_o,
  output logic [N_BANK-1:0]              mode4_o,
  output logic [N_BANK-1:0]              fifo_clr_o,
  output logic [N_BANK-1:0][BYTE_W-1:0]  data_tim_o,
  output logic [N_BANK-1:0][BYTE_W-1:0]  ctl_tim_o
);
  logic [BYTE_W-1:0]             ptr_q;
  logic                          ptr_wr, data_acc, data_wr;
  logic                          bank_sel;
  logic [N_BANK-1:0][DATA_W-1:0] bank_rdata;
  logic [DATA_W-1:0]             rdata_d;
  logic [DATA_W-1:0]             rdata_q;
  logic                          rvalid_q;

  assign ptr_wr   = host_req_i && host_we_i && host_addr_i;
  assign data_acc = host_req_i && !host_addr_i;
  assign data_wr  = data_acc && host_we_i;
  assign bank_sel = ptr_q[PTR_BANK_BIT];

  ide_cfg_ptr #(
    .PW      (BYTE_W),
    .IW      (IDX_W),
    .LAST_IDX(SLOT_CTIM),
    .RST_VAL (PTR_RST),
    .STEP_BIT(PTR_STEP_BIT)
  ) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ptr_wr),
    .wdata_i (host_wdata_i[BYTE_W-1:0]),
    .access_i(data_acc),
    .ptr_o   (ptr_q)
  );

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    ide_cfg_bank #(
      .CMD_RST(CMD_RST[g]),
      .CTL_RST(CTL_RST[g])
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (data_wr && (bank_sel == g[0])),
      .idx_i     (ptr_q[IDX_W-1:0]),
      .wdata_i   (host_wdata_i),
      .rdata_o   (bank_rdata[g]),
      .cmd_base_o(cmd_base_o[g]),
      .ctl_base_o(ctl_base_o[g]),
      .gen_o     (gen_cfg_o[g]),
      .ra_count_o(ra_count_o[g]),
      .ra_en_o   (ra_en_o[g]),
      .mode4_o   (mode4_o[g]),
      .fifo_clr_o(fifo_clr_o[g]),
      .dtim_o    (data_tim_o[g]),
      .ctim_o    (ctl_tim_o[g])
    );
  end

  always_comb begin
    if (host_addr_i) rdata_d = {{(DATA_W-BYTE_W){1'b0}}, ptr_q};
    else             rdata_d = bank_rdata[bank_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_req_i && !host_we_i;
      if (host_req_i && !host_we_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o      = rdata_q;
  assign rvalid_o     = rvalid_q;
  assign post_wait_o  = ptr_q[PTR_WAIT_BIT];
  assign burst_dis_o  = ptr_q[PTR_BURST_BIT];
  assign sel_medium_o = ptr_q[PTR_MED_BIT];
endmodule

// File: rtl/ide_cfg_regs_chk.sv
module ide_cfg_regs_chk (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_req_i,
  input logic             host_we_i,
  input logic             host_addr_i,
  input logic [7:0]       ptr_q,
  input logic             rvalid_o,
  input logic [1:0]       fifo_clr_o,
  input logic [1:0][15:0] cmd_base_o,
  input logic [1:0][15:0] ctl_base_o
);
  logic data_acc;
  assign data_acc = host_req_i && !host_addr_i;

  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && ptr_q[7] && (ptr_q[2:0] < 3'd6) |=> ptr_q[2:0] == $past(ptr_q[2:0]) + 3'd1);

  // R6
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && ptr_q[7] && (ptr_q[2:0] >= 3'd6) |=> ptr_q[2:0] == 3'd0);

  // R6
  step_bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc |=> ptr_q[3] == $past(ptr_q[3]));

  // R3
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i |=> rvalid_o);

  // R3
  no_rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_req_i && !host_we_i) |=> !rvalid_o);

  // R8
  fifo_pulse0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o[0] |=> !fifo_clr_o[0]);

  // R8
  fifo_pulse1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o[1] |=> !fifo_clr_o[1]);

  // R10
  slot7_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && host_we_i && (ptr_q[2:0] == 3'd7) |=> $stable(cmd_base_o) && $stable(ctl_base_o));
endmodule

bind ide_cfg_regs ide_cfg_regs_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_req_i (host_req_i),
  .host_we_i  (host_we_i),
  .host_addr_i(host_addr_i),
  .ptr_q      (ptr_q),
  .rvalid_o   (rvalid_o),
  .fifo_clr_o (fifo_clr_o),
  .cmd_base_o (cmd_base_o),
  .ctl_base_o (ctl_base_o)
);

// File: tb/ide_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module ide_cfg_regs_tb_top;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             host_req_i = 1'b0;
  logic             host_we_i = 1'b0;
  logic             host_addr_i = 1'b0;
  logic [15:0]      host_wdata_i = '0;
  logic [15:0]      rdata_o;
  logic             rvalid_o;
  logic             post_wait_o, burst_dis_o, sel_medium_o;
  logic [1:0][15:0] cmd_base_o, ctl_base_o;
  logic [1:0][7:0]  gen_cfg_o, data_tim_o, ctl_tim_o;
  logic [1:0][9:0]  ra_count_o;
  logic [1:0]       ra_en_o, mode4_o, fifo_clr_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  ide_cfg_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_req_i(host_req_i), .host_we_i(host_we_i),
    .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .post_wait_o(post_wait_o), .burst_dis_o(burst_dis_o),
    .sel_medium_o(sel_medium_o), .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o),
    .gen_cfg_o(gen_cfg_o), .ra_count_o(ra_count_o), .ra_en_o(ra_en_o),
    .mode4_o(mode4_o), .fifo_clr_o(fifo_clr_o), .data_tim_o(data_tim_o),
    .ctl_tim_o(ctl_tim_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic addr, input logic [15:0] d);
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = 1'b1; host_addr_i = addr; host_wdata_i = d;
    @(negedge clk_i);
    host_req_i = 1'b0; host_we_i = 1'b0;
  endtask

  task automatic do_rd(input logic addr, input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = 1'b0; host_addr_i = addr;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    host_req_i = 1'b0;
  endtask

  // monitor: pops one expectation per returned read
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: unexpected read data 0x%04h expected none", rdata_o);
      end else begin
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset pointer and option outputs
    check("R1 post_wait", 16'(post_wait_o), 16'd1);
    check("R1 sel_medium", 16'(sel_medium_o), 16'd1);
    check("R1 burst_dis", 16'(burst_dis_o), 16'd0);
    check("R3 no valid at reset", 16'(rvalid_o), 16'd0);
    do_rd(1'b1, 16'h0050, "R1 pointer reset");

    // R4 bank 0 sweep with auto-step, wrap R6
    do_wr(1'b1, 16'h0080);
    do_rd(1'b0, 16'h01F0, "R4 b0 slot0");
    do_rd(1'b0, 16'h0001, "R4 b0 slot1");
    do_rd(1'b0, 16'h0000, "R5 b0 slot2");
    do_rd(1'b0, 16'h0000, "R5 b0 slot3");
    do_rd(1'b0, 16'h03F6, "R4 b0 slot4");
    do_rd(1'b0, 16'h00F5, "R4 b0 slot5");
    do_rd(1'b0, 16'h00DE, "R4 b0 slot6");
    do_rd(1'b0, 16'h01F0, "R6 b0 wrap");
    do_rd(1'b1, 16'h0081, "R2 pointer after reads");

    // R4 bank 1 sweep
    do_wr(1'b1, 16'h0088);
    do_rd(1'b0, 16'h0170, "R4 b1 slot0");
    do_rd(1'b0, 16'h0001, "R4 b1 slot1");
    do_rd(1'b0, 16'h0000, "R5 b1 slot2");
    do_rd(1'b0, 16'h0000, "R5 b1 slot3");
    do_rd(1'b0, 16'h0376, "R4 b1 slot4");
    do_rd(1'b0, 16'h00F5, "R4 b1 slot5");
    do_rd(1'b0, 16'h00DE, "R4 b1 slot6");
    do_rd(1'b1, 16'h0088, "R6 bank bit kept");

    // R2 auto-step on writes, R7 byte truncation
    do_wr(1'b1, 16'h0085);
    do_wr(1'b0, 16'hAB33);
    do_wr(1'b0, 16'hCD44);
    check("R7 data_tim b0", 16'(data_tim_o[0]), 16'h0033);
    check("R7 ctl_tim b0", 16'(ctl_tim_o[0]), 16'h0044);
    check("R11 data_tim b1", 16'(data_tim_o[1]), 16'h00F5);
    do_rd(1'b1, 16'h0080, "R2 pointer after writes");

    // R7 word slot, R2 no step
    do_wr(1'b1, 16'h0000);
    do_wr(1'b0, 16'h1234);
    do_rd(1'b0, 16'h1234, "R7 word slot0");
    do_rd(1'b0, 16'h1234, "R2 no step");
    do_rd(1'b1, 16'h0000, "R2 pointer held");
    check("R11 cmd_base b0", cmd_base_o[0], 16'h1234);
    check("R11 cmd_base b1", cmd_base_o[1], 16'h0170);

    // R8 read-ahead and FIFO clear pulse
    do_wr(1'b1, 16'h0002);
    do_wr(1'b0, 16'hFFA5);
    do_rd(1'b0, 16'h0000, "R5 slot2 write-only");
    do_wr(1'b1, 16'h0003);
    do_wr(1'b0, 16'hFFC3);
    check("R8 fifo pulse b0", 16'(fifo_clr_o[0]), 16'd1);
    check("R8 fifo b1 quiet", 16'(fifo_clr_o[1]), 16'd0);
    @(negedge clk_i);
    check("R8 fifo pulse ends", 16'(fifo_clr_o[0]), 16'd0);
    check("R8 ra_count", 16'(ra_count_o[0]), 16'h03A5);
    check("R8 ra_en", 16'(ra_en_o[0]), 16'd1);
    check("R8 mode4 off", 16'(mode4_o[0]), 16'd0);
    do_rd(1'b0, 16'h0000, "R5 slot3 write-only");
    do_wr(1'b0, 16'h0010);
    check("R8 no pulse", 16'(fifo_clr_o[0]), 16'd0);
    check("R8 ra_count hi cleared", 16'(ra_count_o[0]), 16'h00A5);
    check("R8 ra_en off", 16'(ra_en_o[0]), 16'd0);
    check("R8 mode4 on", 16'(mode4_o[0]), 16'd1);

    // R9 general control
    do_wr(1'b1, 16'h0001);
    do_wr(1'b0, 16'h55E0);
    check("R9 gen_cfg b0", 16'(gen_cfg_o[0]), 16'h00E0);
    check("R9 gen_cfg b1", 16'(gen_cfg_o[1]), 16'h0001);
    do_rd(1'b0, 16'h00E0, "R9 gen readback");

    // R10 slot 7
    do_wr(1'b1, 16'h0007);
    do_wr(1'b0, 16'hFFFF);
    do_rd(1'b0, 16'h0000, "R10 slot7 read");
    check("R10 cmd_base kept", cmd_base_o[0], 16'h1234);
    check("R10 ctl_base kept", ctl_base_o[0], 16'h03F6);
    check("R10 gen kept", 16'(gen_cfg_o[0]), 16'h00E0);
    check("R10 dtim kept", 16'(data_tim_o[0]), 16'h0033);

    // R3 pointer high byte dropped, R1 options follow
    do_wr(1'b1, 16'hFF28);
    do_rd(1'b1, 16'h0028, "R3 pointer low byte");
    check("R1 burst_dis set", 16'(burst_dis_o), 16'd1);
    check("R1 post_wait clear", 16'(post_wait_o), 16'd0);
    check("R1 sel_medium clear", 16'(sel_medium_o), 16'd0);

    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R3: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule